// File: doc/BRIEF.md
# Memory-Region Scoreboard for Block Operations

This block sits between a processor and a set of block accelerators that copy-and-transform one memory region into another. Each accelerator operation reads a source region and writes a destination region. It keeps no state from one operation to the next. Every region is a power of two bytes in size and is aligned to that size, so it is described by a base address and a log2 size. The scoreboard holds the regions of up to four operations in flight. It stalls processor loads and stores, and newly issued operations, that would touch those regions out of program order. The visible result then matches strictly sequential execution.

Functions are loaded into a small cache of four contexts. An operation whose function is not cached first requests a context load into a chosen way. It then waits for the load to finish before it issues. Free ways are filled first. Once all ways are valid, the least recently used way is replaced.

The issue side is run by a three-state machine:
- `ST_IDLE` waits for a request.
- `ST_FILL` holds a context load request.
- `ST_HOLD` holds a cached request that is blocked by a region hazard or by a full table.

The transitions are:
- *miss* (IDLE or HOLD to FILL, when the function is not cached).
- *block* (IDLE to HOLD, when the function is cached but the request cannot issue).
- *issue* (HOLD to IDLE, when the request is accepted).
- *withdraw* (HOLD to IDLE, when the request is dropped).
- *filled* (FILL to IDLE, when the load completes).

Top module: `region_scoreboard`

## Requirements
- R1: After reset, no entry and no context is valid: `cpu_stall`, `iss_stall` and `ctx_load_req` are 0 while their requests are idle, and the first issued operation misses the context cache.
- R2: A processor load (`cpu_we`=0) stalls, in the same cycle, exactly when its address lies in the destination region of a valid entry. Region `[base, base+2^lg)` has its low `lg` address bits ignored. With `cpu_valid`=0 there is no stall.
- R3: A processor store (`cpu_we`=1) stalls, in the same cycle, exactly when its address lies in the source or the destination region of a valid entry.
- R4: A request stalls while its source overlaps any valid destination, or while its destination overlaps any valid source or destination. Two aligned regions overlap when their bases agree above the larger log2 size. A source that overlaps only valid sources does not stall.
- R5: An accepted request is written into the lowest-numbered free entry, reported on `iss_slot`. When all four entries are valid, a request stalls.
- R6: `done_valid` with `done_slot` clears that entry at the clock edge. A request that the entry was blocking is accepted in the following cycle.
- R7: On a context miss, the request stalls and the block moves to `ST_FILL`. It holds `ctx_load_req` with the function and target way until `ctx_load_done`. The request is accepted in the next cycle, with `iss_way` equal to the loaded way.
- R8: The target way is the lowest-numbered invalid way. When every way is valid, it is the least recently used way. Both an accepted issue and a completed load count as a use.
- R9: A request with a cached function, no hazard and a free entry is accepted in the same cycle it is presented (`iss_accept`=1, `iss_stall`=0), with `iss_way` giving the cached way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Operation request, held until accepted |
| iss_func | input | FUNC_W | Function identifier of the request |
| iss_src_base | input | ADDR_W | Source region base |
| iss_src_lg | input | LOG_W | Source region log2 size |
| iss_dst_base | input | ADDR_W | Destination region base |
| iss_dst_lg | input | LOG_W | Destination region log2 size |
| iss_accept | output | 1 | Request accepted this cycle |
| iss_stall | output | 1 | Request present but not accepted |
| iss_slot | output | SLOT_W | Entry given to the accepted request |
| iss_way | output | WAY_W | Context way holding the request's function |
| ctx_load_req | output | 1 | Context load requested |
| ctx_load_func | output | FUNC_W | Function to load |
| ctx_load_way | output | WAY_W | Way to load it into |
| ctx_load_done | input | 1 | Context load finished |
| done_valid | input | 1 | An operation completed |
| done_slot | input | SLOT_W | Entry of the completed operation |
| cpu_valid | input | 1 | Processor access present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Processor access address |
| cpu_stall | output | 1 | Processor access must wait |

## Verification
Processor accesses are tried against two in-flight operations of different region sizes:
- Loads and stores are aimed at the same source address, which separates the load rule from the store rule.
- Addresses just inside and just outside each region expose mask-width errors.

Issue requests are tried with the following region overlaps:
- source against destination,
- source against source,
- destination against source,
- destination against destination.

These separate the hazard classes from each other. A blocked request is then released by retiring entries one at a time. This shows that only the last blocking entry frees it. A sequence of four fills, followed by a re-use, two evictions and one more eviction, fixes the exact least-recently-used order.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_HOLD = 2'd2
    } iss_state_e;

    // Ones in every bit below position lg; all ones from 64 up.
    function automatic logic [63:0] low_mask(input logic [6:0] lg);
        if (lg >= 7'd64) return {64{1'b1}};
        return (64'd1 << lg) - 64'd1;
    endfunction

endpackage

// File: rtl/rsb_ctx_cache.sv
module rsb_ctx_cache #(
    parameter int NCTX   = 4,
    parameter int FUNC_W = 4,
    parameter int WAY_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUNC_W-1:0] lookup_func,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [WAY_W-1:0]  victim_way,
    input  logic              touch,
    input  logic [WAY_W-1:0]  touch_way,
    input  logic              fill,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [FUNC_W-1:0] fill_func
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NCTX - 1);

    logic [FUNC_W-1:0] tag_q [NCTX];
    logic [WAY_W-1:0]  age_q [NCTX];
    logic [NCTX-1:0]   vld_q;
    logic [NCTX-1:0]   hit_vec;
    logic              upd;
    logic [WAY_W-1:0]  upd_way;

    for (genvar i = 0; i < NCTX; i++) begin : g_match
        assign hit_vec[i] = vld_q[i] && (tag_q[i] == lookup_func);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int i = NCTX - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end

    // Lowest invalid way first, otherwise the oldest way.
    always_comb begin
        victim_way = '0;
        for (int i = NCTX - 1; i >= 0; i--) begin
            if (age_q[i] == OLDEST) victim_way = WAY_W'(i);
        end
        for (int i = NCTX - 1; i >= 0; i--) begin
            if (!vld_q[i]) victim_way = WAY_W'(i);
        end
    end

    assign upd     = fill || touch;
    assign upd_way = fill ? fill_way : touch_way;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < NCTX; i++) begin
                age_q[i] <= WAY_W'(i);
                tag_q[i] <= '0;
            end
        end else begin
            if (upd) begin
                for (int i = 0; i < NCTX; i++) begin
                    if (WAY_W'(i) == upd_way)
                        age_q[i] <= '0;
                    else if (age_q[i] < age_q[upd_way])
                        age_q[i] <= age_q[i] + 1'b1;
                end
            end
            if (fill) begin
                tag_q[fill_way] <= fill_func;
                vld_q[fill_way] <= 1'b1;
            end
        end
    end

    logic [NCTX-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int i = 0; i < NCTX; i++) age_seen[age_q[i]] = 1'b1;
    end

    AST_AGE_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        age_seen == {NCTX{1'b1}}); // R8
    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R7

endmodule

// File: rtl/rsb_slot_table.sv
module rsb_slot_table
    import rsb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LOG_W  = 6,
    parameter int NSLOT  = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [LOG_W-1:0]  src_lg,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [LOG_W-1:0]  dst_lg,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              issue_haz,
    output logic              free_any,
    output logic [SLOT_W-1:0] free_slot,
    output logic              cpu_hit
);
    logic [ADDR_W-1:0] sb_q [NSLOT];
    logic [ADDR_W-1:0] db_q [NSLOT];
    logic [LOG_W-1:0]  sl_q [NSLOT];
    logic [LOG_W-1:0]  dl_q [NSLOT];
    logic [NSLOT-1:0]  vld_q;
    logic [NSLOT-1:0]  haz_vec;
    logic [NSLOT-1:0]  cpu_vec;

    function automatic logic overlap(input logic [ADDR_W-1:0] a, input logic [LOG_W-1:0] la,
                                     input logic [ADDR_W-1:0] b, input logic [LOG_W-1:0] lb);
        logic [LOG_W-1:0] m;
        m = (la > lb) ? la : lb;
        return ((64'(a ^ b)) & ~low_mask(7'(m))) == 64'd0;
    endfunction

    function automatic logic inside_reg(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b, input logic [LOG_W-1:0] lb);
        return ((64'(a ^ b)) & ~low_mask(7'(lb))) == 64'd0;
    endfunction

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic s_on_d, d_on_s, d_on_d, in_src, in_dst;
        assign s_on_d = overlap(src_base, src_lg, db_q[i], dl_q[i]);
        assign d_on_s = overlap(dst_base, dst_lg, sb_q[i], sl_q[i]);
        assign d_on_d = overlap(dst_base, dst_lg, db_q[i], dl_q[i]);
        assign in_src = inside_reg(cpu_addr, sb_q[i], sl_q[i]);
        assign in_dst = inside_reg(cpu_addr, db_q[i], dl_q[i]);
        assign haz_vec[i] = vld_q[i] && (s_on_d || d_on_s || d_on_d);
        assign cpu_vec[i] = vld_q[i] && (in_dst || (cpu_we && in_src));
    end

    assign issue_haz = |haz_vec;
    assign cpu_hit   = cpu_valid && (|cpu_vec);
    assign free_any  = !(&vld_q);

    always_comb begin
        free_slot = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_slot = SLOT_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                sb_q[i] <= '0;
                db_q[i] <= '0;
                sl_q[i] <= '0;
                dl_q[i] <= '0;
            end
        end else begin
            if (done_valid) vld_q[done_slot] <= 1'b0;
            if (alloc) begin
                vld_q[free_slot] <= 1'b1;
                sb_q[free_slot]  <= src_base;
                sl_q[free_slot]  <= src_lg;
                db_q[free_slot]  <= dst_base;
                dl_q[free_slot]  <= dst_lg;
            end
        end
    end

    AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> free_any); // R5
    AST_ALLOC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !issue_haz); // R4
    AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !(alloc && free_slot == done_slot)) |=> !vld_q[$past(done_slot)]); // R6

endmodule

// File: rtl/rsb_issue_fsm.sv
module rsb_issue_fsm
    import rsb_pkg::*;
#(
    parameter int FUNC_W = 4,
    parameter int WAY_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [FUNC_W-1:0] iss_func,
    input  logic              ctx_hit,
    input  logic [WAY_W-1:0]  victim_way,
    input  logic              blocked,
    input  logic              load_done,
    output logic              accept,
    output logic              stall,
    output logic              load_req,
    output logic [FUNC_W-1:0] load_func,
    output logic [WAY_W-1:0]  load_way,
    output logic              fill
);
    iss_state_e        state_q, state_d;
    logic [FUNC_W-1:0] lfunc_q;
    logic [WAY_W-1:0]  lway_q;
    logic              start_fill;

    // State register and captured load target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lfunc_q <= '0;
            lway_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_fill) begin
                lfunc_q <= iss_func;
                lway_q  <= victim_way;
            end
        end
    end

    // Next state.
    always_comb begin
        state_d    = state_q;
        start_fill = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                if (!iss_valid) begin
                    state_d = ST_IDLE;
                end else if (!ctx_hit) begin
                    state_d    = ST_FILL;
                    start_fill = 1'b1;
                end else if (blocked) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_FILL: begin
                if (load_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        accept   = 1'b0;
        load_req = 1'b0;
        fill     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_HOLD: accept = iss_valid && ctx_hit && !blocked;
            ST_FILL: begin
                load_req = 1'b1;
                fill     = load_done;
            end
            default: ;
        endcase
        stall     = iss_valid && !accept;
        load_func = lfunc_q;
        load_way  = lway_q;
    end

    AST_FILL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> !accept); // R7
    AST_LOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && !load_done) |=> (load_req && $stable(load_func) && $stable(load_way))); // R7
    AST_MISS_ENTERS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FILL && iss_valid && !ctx_hit) |=> load_req); // R7

endmodule

// File: rtl/region_scoreboard.sv
module region_scoreboard #(
    parameter int ADDR_W = 32,
    parameter int LOG_W  = 6,
    parameter int NSLOT  = 4,
    parameter int NCTX   = 4,
    parameter int FUNC_W = 4,
    parameter int SLOT_W = $clog2(NSLOT),
    parameter int WAY_W  = $clog2(NCTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [FUNC_W-1:0] iss_func,
    input  logic [ADDR_W-1:0] iss_src_base,
    input  logic [LOG_W-1:0]  iss_src_lg,
    input  logic [ADDR_W-1:0] iss_dst_base,
    input  logic [LOG_W-1:0]  iss_dst_lg,
    output logic              iss_accept,
    output logic              iss_stall,
    output logic [SLOT_W-1:0] iss_slot,
    output logic [WAY_W-1:0]  iss_way,
    output logic              ctx_load_req,
    output logic [FUNC_W-1:0] ctx_load_func,
    output logic [WAY_W-1:0]  ctx_load_way,
    input  logic              ctx_load_done,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_stall
);
    logic             ctx_hit, issue_haz, free_any, fill;
    logic [WAY_W-1:0] hit_way, victim_way;

    rsb_ctx_cache #(.NCTX(NCTX), .FUNC_W(FUNC_W), .WAY_W(WAY_W)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .lookup_func(iss_func), .hit(ctx_hit), .hit_way(hit_way), .victim_way(victim_way),
        .touch(iss_accept), .touch_way(hit_way),
        .fill(fill), .fill_way(ctx_load_way), .fill_func(ctx_load_func)
    );

    rsb_slot_table #(.ADDR_W(ADDR_W), .LOG_W(LOG_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .alloc(iss_accept),
        .src_base(iss_src_base), .src_lg(iss_src_lg),
        .dst_base(iss_dst_base), .dst_lg(iss_dst_lg),
        .done_valid(done_valid), .done_slot(done_slot),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .issue_haz(issue_haz), .free_any(free_any), .free_slot(iss_slot), .cpu_hit(cpu_stall)
    );

    rsb_issue_fsm #(.FUNC_W(FUNC_W), .WAY_W(WAY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_func(iss_func),
        .ctx_hit(ctx_hit), .victim_way(victim_way),
        .blocked(issue_haz || !free_any), .load_done(ctx_load_done),
        .accept(iss_accept), .stall(iss_stall),
        .load_req(ctx_load_req), .load_func(ctx_load_func), .load_way(ctx_load_way),
        .fill(fill)
    );

    assign iss_way = hit_way;

    AST_CPU_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> !cpu_stall); // R2
    AST_ACCEPT_XOR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_accept && iss_stall)); // R9

endmodule

// File: tb/sim_region_scoreboard.sv
module sim_region_scoreboard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_func = '0;
    logic [31:0] iss_src_base = '0, iss_dst_base = '0;
    logic [5:0]  iss_src_lg = '0, iss_dst_lg = '0;
    logic        iss_accept, iss_stall, ctx_load_req;
    logic [1:0]  iss_slot, iss_way, ctx_load_way;
    logic [3:0]  ctx_load_func;
    logic        ctx_load_done = 1'b0;
    logic        done_valid = 1'b0;
    logic [1:0]  done_slot = '0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_stall;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    region_scoreboard u0 (.*);

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic present(input logic [3:0] f, input logic [31:0] sb, input logic [5:0] sl,
                           input logic [31:0] db, input logic [5:0] dl);
        @(negedge clk);
        iss_valid = 1'b1; iss_func = f;
        iss_src_base = sb; iss_src_lg = sl; iss_dst_base = db; iss_dst_lg = dl;
        #1;
    endtask

    task automatic expect_accept(input string req, input logic [1:0] slot, input logic [1:0] way);
        chk(iss_accept == 1'b1 && iss_stall == 1'b0, req, "accept", iss_accept, 1);
        chk(iss_slot == slot, req, "slot", iss_slot, slot);
        chk(iss_way == way, req, "way", iss_way, way);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic issue_hit(input logic [3:0] f, input logic [31:0] sb, input logic [5:0] sl,
                             input logic [31:0] db, input logic [5:0] dl,
                             input logic [1:0] slot, input logic [1:0] way);
        present(f, sb, sl, db, dl);
        expect_accept("R9", slot, way);
    endtask

    task automatic issue_miss(input logic [3:0] f, input logic [31:0] sb, input logic [5:0] sl,
                              input logic [31:0] db, input logic [5:0] dl,
                              input logic [1:0] way, input logic [1:0] slot);
        present(f, sb, sl, db, dl);
        chk(iss_stall == 1'b1 && iss_accept == 1'b0, "R7", "miss stall", iss_stall, 1);
        @(negedge clk); #1;
        chk(ctx_load_req == 1'b1, "R7", "load req", ctx_load_req, 1);
        chk(ctx_load_func == f, "R7", "load func", ctx_load_func, f);
        chk(ctx_load_way == way, "R8", "load way", ctx_load_way, way);
        chk(iss_accept == 1'b0, "R7", "no accept in fill", iss_accept, 0);
        ctx_load_done = 1'b1;
        @(negedge clk);
        ctx_load_done = 1'b0;
        #1;
        chk(ctx_load_req == 1'b0, "R7", "load req cleared", ctx_load_req, 0);
        expect_accept("R7", slot, way);
    endtask

    task automatic retire(input logic [1:0] s);
        @(negedge clk);
        done_valid = 1'b1; done_slot = s;
        @(negedge clk);
        done_valid = 1'b0;
        #1;
    endtask

    // {store, address, expected stall}
    localparam logic [33:0] CPU_VEC [10] = '{
        {1'b0, 32'h0000_1010, 1'b0},
        {1'b1, 32'h0000_1010, 1'b1},
        {1'b0, 32'h0000_20FF, 1'b1},
        {1'b1, 32'h0000_2100, 1'b0},
        {1'b0, 32'h0000_5ABC, 1'b1},
        {1'b1, 32'h0000_400F, 1'b1},
        {1'b0, 32'h0000_400F, 1'b0},
        {1'b1, 32'h0000_3000, 1'b0},
        {1'b0, 32'h0000_4010, 1'b0},
        {1'b1, 32'h0000_5FFF, 1'b1}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h0;
        #1;
        // R1: idle outputs after reset
        chk(cpu_stall == 1'b0, "R1", "cpu_stall", cpu_stall, 0);
        chk(iss_stall == 1'b0, "R1", "iss_stall", iss_stall, 0);
        chk(ctx_load_req == 1'b0, "R1", "ctx_load_req", ctx_load_req, 0);
        cpu_valid = 1'b0;

        // R1 first issue misses; R7 fill into way 0
        issue_miss(4'd3, 32'h1000, 6'd8, 32'h2000, 6'd8, 2'd0, 2'd0);
        // R9 hit, R5 next free slot
        issue_hit(4'd3, 32'h4000, 6'd4, 32'h5000, 6'd12, 2'd1, 2'd0);

        // R2/R3 processor checks walked from the table
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            cpu_valid = 1'b1; cpu_we = CPU_VEC[k][33]; cpu_addr = CPU_VEC[k][32:1];
            #1;
            chk(cpu_stall == CPU_VEC[k][0], CPU_VEC[k][33] ? "R3" : "R2",
                "cpu table", cpu_stall, CPU_VEC[k][0]);
        end
        @(negedge clk);
        cpu_valid = 1'b0; cpu_we = 1'b1; cpu_addr = 32'h1010;
        #1;
        chk(cpu_stall == 1'b0, "R2", "no access no stall", cpu_stall, 0);

        // R4 source over in-flight destination, released by R6
        present(4'd3, 32'h2080, 6'd4, 32'h8000, 6'd8);
        chk(iss_stall == 1'b1, "R4", "src on dst stall", iss_stall, 1);
        @(negedge clk); #1;
        chk(iss_stall == 1'b1 && iss_accept == 1'b0, "R4", "still held", iss_stall, 1);
        done_valid = 1'b1; done_slot = 2'd0;
        @(negedge clk);
        done_valid = 1'b0;
        #1;
        expect_accept("R6", 2'd0, 2'd0);

        // R4 source over in-flight source only: no stall
        issue_hit(4'd3, 32'h4000, 6'd2, 32'hA000, 6'd4, 2'd2, 2'd0);

        // R4 destination over in-flight sources (slots 1 and 2)
        present(4'd3, 32'h9000, 6'd4, 32'h4000, 6'd8);
        chk(iss_stall == 1'b1, "R4", "dst on src stall", iss_stall, 1);
        done_valid = 1'b1; done_slot = 2'd1;
        @(negedge clk);
        done_valid = 1'b0;
        #1;
        chk(iss_stall == 1'b1, "R6", "one blocker left", iss_stall, 1);
        done_valid = 1'b1; done_slot = 2'd2;
        @(negedge clk);
        done_valid = 1'b0;
        #1;
        expect_accept("R6", 2'd1, 2'd0);

        // R4 destination over in-flight destination, then withdrawn
        present(4'd3, 32'h7000, 6'd4, 32'h8040, 6'd4);
        chk(iss_stall == 1'b1, "R4", "dst on dst stall", iss_stall, 1);
        @(negedge clk);
        iss_valid = 1'b0;
        #1;
        chk(iss_stall == 1'b0, "R4", "withdrawn", iss_stall, 0);

        // R5 fill table, fifth request waits
        issue_hit(4'd3, 32'hB000, 6'd4, 32'hC000, 6'd4, 2'd2, 2'd0);
        issue_hit(4'd3, 32'hB100, 6'd4, 32'hD000, 6'd4, 2'd3, 2'd0);
        present(4'd3, 32'hE000, 6'd4, 32'hF000, 6'd4);
        chk(iss_stall == 1'b1, "R5", "table full stall", iss_stall, 1);
        done_valid = 1'b1; done_slot = 2'd3;
        @(negedge clk);
        done_valid = 1'b0;
        #1;
        expect_accept("R5", 2'd3, 2'd0);

        for (int s = 0; s < 4; s++) retire(2'(s));
        cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h2080;
        #1;
        chk(cpu_stall == 1'b0, "R6", "retired region free", cpu_stall, 0);
        cpu_valid = 1'b0;

        // R8 fill free ways, then LRU replacement
        issue_miss(4'd5, 32'h10000, 6'd4, 32'h11000, 6'd4, 2'd1, 2'd0); retire(2'd0);
        issue_miss(4'd6, 32'h10000, 6'd4, 32'h11000, 6'd4, 2'd2, 2'd0); retire(2'd0);
        issue_miss(4'd7, 32'h10000, 6'd4, 32'h11000, 6'd4, 2'd3, 2'd0); retire(2'd0);
        issue_hit(4'd5, 32'h10000, 6'd4, 32'h11000, 6'd4, 2'd0, 2'd1);  retire(2'd0);
        issue_miss(4'd9, 32'h10000, 6'd4, 32'h11000, 6'd4, 2'd0, 2'd0); retire(2'd0);
        issue_miss(4'd3, 32'h10000, 6'd4, 32'h11000, 6'd4, 2'd2, 2'd0); retire(2'd0);
        issue_hit(4'd5, 32'h10000, 6'd4, 32'h11000, 6'd4, 2'd0, 2'd1);  retire(2'd0);
        issue_miss(4'd6, 32'h10000, 6'd4, 32'h11000, 6'd4, 2'd3, 2'd0); retire(2'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule